// File: doc/BRIEF.md
# Banked GPIO Controller with Edge, Level and Wake Events

This block is a memory-mapped general-purpose I/O controller. Pins are grouped into banks of 32. Every register kind has its own base offset, and the words for successive banks follow that base at a 4-byte stride. Software drives the output latch only through write-one set and clear words. A direction word decides which pins drive, and a level word reads back what every pin currently shows.

Each input passes through a two-flop synchronizer. It then goes either through a stability filter or around it, which a per-pin bypass bit selects. The conditioned signal feeds per-pin event detection. In edge mode, enabled rising or falling transitions are caught. In level mode, a qualified level is caught for as long as it lasts, and a polarity bit picks active-high or active-low.

Caught events collect in a write-one-to-clear status word, and a single interrupt line reports any status bit whose mask bit is open. A separate wake mask copies events into a write-one-to-clear wake status word, which drives a wake request line. The register port is a plain 32-bit word port with no back-pressure. A write takes effect at the clock edge on which it is presented, and read data is a combinational function of the address.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Pin p lives in bank p/32 at bit p%32. A register word's byte address is its base plus 4 times the bank index. The bases are: control 0x000 (one word only, read/write, not banked), level 0x004 (read-only), direction 0x01C, set 0x034 (write-only, reads 0), clear 0x04C (write-only, reads 0), rising enable 0x064, falling enable 0x07C, filter bypass 0x094, interrupt mask 0x0AC, interrupt status 0x0C4, input mode 0x300, level polarity 0x318, wake mask 0x330 and wake status 0x348.
- R2: A 1 written to a bit of the set word drives that pin's output latch (pin_out) high. A 1 written to the clear word drives it low. Bits written as 0 leave the latch unchanged. The change is visible right after the write's clock edge.
- R3: A direction bit of 1 makes the pin an output (pin_oe high) and 0 makes it an input. The level word returns the output latch for output pins and the conditioned input for input pins.
- R4: With the input mode bit at 0, a rising edge of the conditioned input sets the status bit when the rising enable is 1. A falling edge sets it when the falling enable is 1. Both enables may be set together.
- R5: With the input mode bit at 1 the pin is level-sensitive. A polarity bit of 0 means active-high and 1 means active-low. The status bit is set on every cycle in which the active level holds.
- R6: irq is high exactly when some status bit and its mask bit are both 1. A masked status bit stays readable.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a new event for the same bit arrives in the same cycle as the clear, the event wins and the bit stays set.
- R8: With the bypass bit at 1, the synchronized input is used directly. With it at 0, a new value passes only after 3 consecutive cycles of stability, which adds 3 cycles of latency. A pulse of 2 cycles is dropped.
- R9: When a pin whose wake mask bit is 1 sees an event, its wake status bit is set. Wake status is write-one-to-clear, and wake_req is high while any wake status bit is 1. Wake mask and interrupt mask do not affect each other.
- R10: After reset every register is 0, including both edge enables. pin_out, pin_oe, irq and wake_req are all low.
- R11: In bypass mode, an input change shows in the level word after 2 clock edges and in status and irq after 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 12 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pin_in | input | NUM_BANKS*32 | Asynchronous pin inputs |
| pin_out | output | NUM_BANKS*32 | Output latch |
| pin_oe | output | NUM_BANKS*32 | Output enable (direction) |
| irq | output | 1 | Combined interrupt |
| wake_req | output | 1 | Combined wake request |

## Verification
On every cycle, the assertions check the following for the first bank: set and clear writes land on the latch, direction writes land on the output enables, a status clear takes effect unless an event arrives with it, a coinciding event keeps the bit set, wake-masked events raise the wake request, and irq is never high without pending status. The bench scenarios show what needs timed stimulus: the exact 2 and 3 cycle synchronizer latency, the filter dropping a two-cycle glitch and passing a held level 3 cycles later, each edge-enable combination on pins at both bank boundaries, polarity selection in level mode, and address decoding across both banks.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 12;
  localparam int BANK_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CTL  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_LVL  = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 12'h01C;
  localparam logic [ADDR_W-1:0] OFS_SET  = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 12'h04C;
  localparam logic [ADDR_W-1:0] OFS_REN  = 12'h064;
  localparam logic [ADDR_W-1:0] OFS_FEN  = 12'h07C;
  localparam logic [ADDR_W-1:0] OFS_BYP  = 12'h094;
  localparam logic [ADDR_W-1:0] OFS_MSK  = 12'h0AC;
  localparam logic [ADDR_W-1:0] OFS_STS  = 12'h0C4;
  localparam logic [ADDR_W-1:0] OFS_MODE = 12'h300;
  localparam logic [ADDR_W-1:0] OFS_POL  = 12'h318;
  localparam logic [ADDR_W-1:0] OFS_WMSK = 12'h330;
  localparam logic [ADDR_W-1:0] OFS_WSTS = 12'h348;

  // Per-bank software-writable state
  typedef struct packed {
    logic [BANK_W-1:0] dir;
    logic [BANK_W-1:0] latch;
    logic [BANK_W-1:0] ren;
    logic [BANK_W-1:0] fen;
    logic [BANK_W-1:0] byp;
    logic [BANK_W-1:0] msk;
    logic [BANK_W-1:0] mode;
    logic [BANK_W-1:0] pol;
    logic [BANK_W-1:0] wmsk;
  } bank_cfg_t;

  function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] base,
                                                  input int bank);
    return base + ADDR_W'(bank * 4);
  endfunction
endpackage

// File: rtl/gpio_in_cond.sv
// Two-flop synchronizer plus per-pin stability filter with bypass select.
module gpio_in_cond #(
  parameter int NUM_PINS = 64,
  parameter int FILT_CYC = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] byp,
  output logic [NUM_PINS-1:0] cond
);
  localparam int CW = $clog2(FILT_CYC + 1);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic          s1_q, s2_q, filt_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        filt_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        s1_q <= pin_in[i];
        s2_q <= s1_q;
        if (s2_q == filt_q) begin
          cnt_q <= '0;
        end else if (cnt_q == CW'(FILT_CYC - 1)) begin
          filt_q <= s2_q;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end

    assign cond[i] = byp[i] ? s2_q : filt_q;
  end
endmodule

// File: rtl/gpio_evt_detect.sv
// Edge / level event detection, interrupt status and wake status.
module gpio_evt_detect #(
  parameter int NUM_PINS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] cond,
  input  logic [NUM_PINS-1:0] ren,
  input  logic [NUM_PINS-1:0] fen,
  input  logic [NUM_PINS-1:0] mode,
  input  logic [NUM_PINS-1:0] pol,
  input  logic [NUM_PINS-1:0] wmsk,
  input  logic [NUM_PINS-1:0] sts_clr,
  input  logic [NUM_PINS-1:0] wsts_clr,
  output logic [NUM_PINS-1:0] hit,
  output logic [NUM_PINS-1:0] sts,
  output logic [NUM_PINS-1:0] wsts
);
  logic [NUM_PINS-1:0] cond_d;
  logic [NUM_PINS-1:0] rise, fall, act_lvl, edge_hit;

  always_comb begin
    rise     = cond & ~cond_d;
    fall     = ~cond & cond_d;
    // polarity qualifies the level before the mode select picks it
    act_lvl  = cond ^ pol;
    edge_hit = (rise & ren) | (fall & fen);
    hit      = (mode & act_lvl) | (~mode & edge_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_d <= '0;
      sts    <= '0;
      wsts   <= '0;
    end else begin
      cond_d <= cond;
      sts    <= (sts & ~sts_clr) | hit;
      wsts   <= (wsts & ~wsts_clr) | (hit & wmsk);
    end
  end
endmodule

// File: rtl/gpio_regfile.sv
// Banked register storage, write decode and read multiplexer.
module gpio_regfile
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  localparam int NP = NUM_BANKS * BANK_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [BANK_W-1:0]           wdata,
  input  logic [NP-1:0]               level,
  input  logic [NP-1:0]               sts,
  input  logic [NP-1:0]               wsts,
  output bank_cfg_t [NUM_BANKS-1:0]   cfg,
  output logic [NP-1:0]               sts_clr,
  output logic [NP-1:0]               wsts_clr,
  output logic [BANK_W-1:0]           rdata
);
  logic [BANK_W-1:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else if (wr_en && addr == OFS_CTL) ctl_q <= wdata;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg[b] <= '0;
      end else if (wr_en) begin
        if (addr == word_addr(OFS_DIR, b))  cfg[b].dir   <= wdata;
        if (addr == word_addr(OFS_SET, b))  cfg[b].latch <= cfg[b].latch | wdata;
        if (addr == word_addr(OFS_CLR, b))  cfg[b].latch <= cfg[b].latch & ~wdata;
        if (addr == word_addr(OFS_REN, b))  cfg[b].ren   <= wdata;
        if (addr == word_addr(OFS_FEN, b))  cfg[b].fen   <= wdata;
        if (addr == word_addr(OFS_BYP, b))  cfg[b].byp   <= wdata;
        if (addr == word_addr(OFS_MSK, b))  cfg[b].msk   <= wdata;
        if (addr == word_addr(OFS_MODE, b)) cfg[b].mode  <= wdata;
        if (addr == word_addr(OFS_POL, b))  cfg[b].pol   <= wdata;
        if (addr == word_addr(OFS_WMSK, b)) cfg[b].wmsk  <= wdata;
      end
    end

    assign sts_clr[b*BANK_W +: BANK_W] =
      (wr_en && addr == word_addr(OFS_STS, b)) ? wdata : '0;
    assign wsts_clr[b*BANK_W +: BANK_W] =
      (wr_en && addr == word_addr(OFS_WSTS, b)) ? wdata : '0;
  end

  always_comb begin
    rdata = '0;
    if (addr == OFS_CTL) rdata = ctl_q;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr == word_addr(OFS_LVL, b))  rdata = level[b*BANK_W +: BANK_W];
      if (addr == word_addr(OFS_DIR, b))  rdata = cfg[b].dir;
      if (addr == word_addr(OFS_REN, b))  rdata = cfg[b].ren;
      if (addr == word_addr(OFS_FEN, b))  rdata = cfg[b].fen;
      if (addr == word_addr(OFS_BYP, b))  rdata = cfg[b].byp;
      if (addr == word_addr(OFS_MSK, b))  rdata = cfg[b].msk;
      if (addr == word_addr(OFS_STS, b))  rdata = sts[b*BANK_W +: BANK_W];
      if (addr == word_addr(OFS_MODE, b)) rdata = cfg[b].mode;
      if (addr == word_addr(OFS_POL, b))  rdata = cfg[b].pol;
      if (addr == word_addr(OFS_WMSK, b)) rdata = cfg[b].wmsk;
      if (addr == word_addr(OFS_WSTS, b)) rdata = wsts[b*BANK_W +: BANK_W];
    end
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int FILT_CYC  = 3,
  localparam int NP = NUM_BANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BANK_W-1:0] reg_wdata,
  output logic [BANK_W-1:0] reg_rdata,
  input  logic [NP-1:0]     pin_in,
  output logic [NP-1:0]     pin_out,
  output logic [NP-1:0]     pin_oe,
  output logic              irq,
  output logic              wake_req
);
  bank_cfg_t [NUM_BANKS-1:0] cfg;
  logic [NP-1:0] dir_v, latch_v, ren_v, fen_v, byp_v, msk_v, mode_v, pol_v, wmsk_v;
  logic [NP-1:0] cond_v, level_v, evt_hit, sts_v, wsts_v, sts_clr, wsts_clr;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_flat
    assign dir_v  [b*BANK_W +: BANK_W] = cfg[b].dir;
    assign latch_v[b*BANK_W +: BANK_W] = cfg[b].latch;
    assign ren_v  [b*BANK_W +: BANK_W] = cfg[b].ren;
    assign fen_v  [b*BANK_W +: BANK_W] = cfg[b].fen;
    assign byp_v  [b*BANK_W +: BANK_W] = cfg[b].byp;
    assign msk_v  [b*BANK_W +: BANK_W] = cfg[b].msk;
    assign mode_v [b*BANK_W +: BANK_W] = cfg[b].mode;
    assign pol_v  [b*BANK_W +: BANK_W] = cfg[b].pol;
    assign wmsk_v [b*BANK_W +: BANK_W] = cfg[b].wmsk;
  end

  gpio_regfile #(.NUM_BANKS(NUM_BANKS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .level    (level_v),
    .sts      (sts_v),
    .wsts     (wsts_v),
    .cfg      (cfg),
    .sts_clr  (sts_clr),
    .wsts_clr (wsts_clr),
    .rdata    (reg_rdata)
  );

  gpio_in_cond #(.NUM_PINS(NP), .FILT_CYC(FILT_CYC)) u_cond (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (pin_in),
    .byp    (byp_v),
    .cond   (cond_v)
  );

  gpio_evt_detect #(.NUM_PINS(NP)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .cond     (cond_v),
    .ren      (ren_v),
    .fen      (fen_v),
    .mode     (mode_v),
    .pol      (pol_v),
    .wmsk     (wmsk_v),
    .sts_clr  (sts_clr),
    .wsts_clr (wsts_clr),
    .hit      (evt_hit),
    .sts      (sts_v),
    .wsts     (wsts_v)
  );

  assign level_v  = (dir_v & latch_v) | (~dir_v & cond_v);
  assign pin_out  = latch_v;
  assign pin_oe   = dir_v;
  assign irq      = |(sts_v & msk_v);
  assign wake_req = |wsts_v;
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
  import gpio_bank_pkg::*;
#(
  parameter int NP = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [BANK_W-1:0] reg_wdata,
  input logic [NP-1:0]     pin_out,
  input logic [NP-1:0]     pin_oe,
  input logic              irq,
  input logic              wake_req,
  input logic [NP-1:0]     evt_hit,
  input logic [NP-1:0]     sts_v,
  input logic [NP-1:0]     wmsk_v
);
  a_r2_set_high: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_SET) |=>
      ((pin_out[BANK_W-1:0] & $past(reg_wdata)) == $past(reg_wdata)));

  a_r2_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_CLR) |=>
      ((pin_out[BANK_W-1:0] & $past(reg_wdata)) == '0));

  a_r3_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_DIR) |=> (pin_oe[BANK_W-1:0] == $past(reg_wdata)));

  a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_STS && reg_wdata[0] && !evt_hit[0]) |=> !sts_v[0]);

  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hit[0] |=> sts_v[0]);

  a_r9_wake_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_hit[0] && wmsk_v[0]) |=> wake_req);

  a_r6_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts_v != '0));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NP(NP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .wake_req  (wake_req),
  .evt_hit   (evt_hit),
  .sts_v     (sts_v),
  .wmsk_v    (wmsk_v)
);

// File: tb/tb_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_bank_ctrl;
  import gpio_bank_pkg::*;
  localparam int NB = 2;
  localparam int NP = NB * 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic irq, wake_req;

  int n_tests = 0;
  int n_fail  = 0;
  logic [NP-1:0] out_m = '0;

  always #4 clk = ~clk;

  gpio_bank_ctrl #(.NUM_BANKS(NB), .FILT_CYC(3)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .wake_req(wake_req));

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    #(8 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [NP-1:0] pat;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R10 reset state
    chk("R10 irq", 64'(irq), 0);
    chk("R10 wake_req", 64'(wake_req), 0);
    chk("R10 pin_oe", 64'(pin_oe), 0);
    chk("R10 pin_out", 64'(pin_out), 0);
    rd(word_addr(OFS_REN, 1), r); chk("R10 rising enable", 64'(r), 0);
    rd(word_addr(OFS_FEN, 0), r); chk("R10 falling enable", 64'(r), 0);

    // R1 control word is a single read/write word
    wr(OFS_CTL, 32'h1234_ABCD);
    rd(OFS_CTL, r); chk("R1 control word", 64'(r), 64'h1234_ABCD);

    // R2 set sweep over every pin, then clear odd pins
    for (int p = 0; p < NP; p++) begin
      wr(word_addr(OFS_SET, p / 32), 32'(1) << (p % 32));
      out_m[p] = 1'b1;
      chk("R2 set", 64'(pin_out), 64'(out_m));
    end
    for (int p = 1; p < NP; p += 2) begin
      wr(word_addr(OFS_CLR, p / 32), 32'(1) << (p % 32));
      out_m[p] = 1'b0;
      chk("R2 clear", 64'(pin_out), 64'(out_m));
    end
    rd(word_addr(OFS_SET, 0), r); chk("R1 set reads zero", 64'(r), 0);

    // R3 direction and level readback of outputs
    wr(word_addr(OFS_DIR, 0), 32'hFFFF_FFFF);
    wr(word_addr(OFS_DIR, 1), 32'hFFFF_FFFF);
    chk("R3 pin_oe", 64'(pin_oe), {NP{1'b1}});
    rd(word_addr(OFS_LVL, 0), r); chk("R3 level out bank0", 64'(r), 64'(out_m[31:0]));
    rd(word_addr(OFS_LVL, 1), r); chk("R3 level out bank1", 64'(r), 64'(out_m[63:32]));
    wr(word_addr(OFS_DIR, 0), 32'h0);
    wr(word_addr(OFS_DIR, 1), 32'h0);

    // R11 bypass latency on level readback
    wr(word_addr(OFS_BYP, 0), 32'hFFFF_FFFF);
    wr(word_addr(OFS_BYP, 1), 32'hFFFF_FFFF);
    pat = 64'hA5C3_0F96_5A3C_F069;
    pin_in = pat;
    step(1);
    rd(word_addr(OFS_LVL, 0), r); chk("R11 level not yet", 64'(r), 0);
    step(1);
    rd(word_addr(OFS_LVL, 0), r); chk("R11 R3 level in bank0", 64'(r), 64'(pat[31:0]));
    rd(word_addr(OFS_LVL, 1), r); chk("R11 R3 level in bank1", 64'(r), 64'(pat[63:32]));
    pin_in = '0;
    step(6);

    // R4 edge sweep: pins at bank boundaries, all enable combinations
    foreach (pat[k]) begin end
    for (int i = 0; i < 6; i++) begin
      int p;
      p = (i == 0) ? 0 : (i == 1) ? 9 : (i == 2) ? 31 : (i == 3) ? 32 : (i == 4) ? 50 : 63;
      for (int m = 0; m < 4; m++) begin
        logic [31:0] one;
        int bk;
        bk = p / 32;
        one = 32'(1) << (p % 32);
        wr(word_addr(OFS_REN, bk), m[0] ? one : 32'h0);
        wr(word_addr(OFS_FEN, bk), m[1] ? one : 32'h0);
        wr(word_addr(OFS_MSK, bk), one);
        pin_in[p] = 1'b1;
        step(2);
        chk("R11 irq not before 3 edges", 64'(irq), 0);
        step(1);
        chk("R4 rising", 64'(irq), 64'(m[0]));
        rd(word_addr(OFS_STS, bk), r);
        chk("R1 R4 status bit", 64'(r), m[0] ? 64'(one) : 0);
        wr(word_addr(OFS_STS, bk), 32'hFFFF_FFFF);
        chk("R7 clear", 64'(irq), 0);
        pin_in[p] = 1'b0;
        step(3);
        chk("R4 falling", 64'(irq), 64'(m[1]));
        wr(word_addr(OFS_STS, bk), 32'hFFFF_FFFF);
        wr(word_addr(OFS_REN, bk), 32'h0);
        wr(word_addr(OFS_FEN, bk), 32'h0);
        wr(word_addr(OFS_MSK, bk), 32'h0);
      end
    end

    // R6 masked status stays readable, irq follows mask
    wr(word_addr(OFS_REN, 0), 32'h200);
    pin_in[9] = 1'b1;
    step(3);
    chk("R6 masked irq", 64'(irq), 0);
    rd(word_addr(OFS_STS, 0), r); chk("R6 masked status", 64'(r), 64'h200);
    wr(word_addr(OFS_MSK, 0), 32'h200);
    chk("R6 unmasked irq", 64'(irq), 1);
    wr(word_addr(OFS_STS, 0), 32'h0);
    chk("R7 zero write keeps", 64'(irq), 1);
    wr(word_addr(OFS_STS, 0), 32'h200);
    chk("R7 one write clears", 64'(irq), 0);
    pin_in[9] = 1'b0;
    wr(word_addr(OFS_REN, 0), 32'h0);
    wr(word_addr(OFS_MSK, 0), 32'h0);
    step(4);

    // R5 level mode with polarity, R7 event wins over clear
    wr(word_addr(OFS_POL, 0), 32'h0);
    wr(word_addr(OFS_MODE, 0), 32'h8);
    wr(word_addr(OFS_MSK, 0), 32'h8);
    step(1);
    chk("R5 active-high idle", 64'(irq), 0);
    pin_in[3] = 1'b1;
    step(3);
    chk("R5 active-high", 64'(irq), 1);
    wr(word_addr(OFS_STS, 0), 32'h8);
    chk("R7 event wins", 64'(irq), 1);
    pin_in[3] = 1'b0;
    step(3);
    wr(word_addr(OFS_STS, 0), 32'h8);
    chk("R5 level released", 64'(irq), 0);
    wr(word_addr(OFS_POL, 0), 32'h8);
    step(1);
    chk("R5 active-low", 64'(irq), 1);
    pin_in[3] = 1'b1;
    step(3);
    wr(word_addr(OFS_STS, 0), 32'h8);
    chk("R5 active-low released", 64'(irq), 0);
    wr(word_addr(OFS_MODE, 0), 32'h0);
    wr(word_addr(OFS_POL, 0), 32'h0);
    wr(word_addr(OFS_MSK, 0), 32'h0);
    pin_in[3] = 1'b0;
    step(4);

    // R8 filter: 2-cycle glitch dropped, held level passes 3 cycles later
    wr(word_addr(OFS_BYP, 0), ~32'h80);
    wr(word_addr(OFS_REN, 0), 32'h80);
    wr(word_addr(OFS_MSK, 0), 32'h80);
    pin_in[7] = 1'b1;
    step(2);
    pin_in[7] = 1'b0;
    step(8);
    chk("R8 glitch dropped", 64'(irq), 0);
    pin_in[7] = 1'b1;
    step(5);
    chk("R8 filtered not yet", 64'(irq), 0);
    step(1);
    chk("R8 filtered edge", 64'(irq), 1);
    rd(word_addr(OFS_LVL, 0), r); chk("R8 level after filter", 64'(r[7]), 1);
    pin_in[7] = 1'b0;
    step(8);
    wr(word_addr(OFS_STS, 0), 32'hFFFF_FFFF);
    wr(word_addr(OFS_BYP, 0), 32'hFFFF_FFFF);
    wr(word_addr(OFS_REN, 0), 32'h0);
    wr(word_addr(OFS_MSK, 0), 32'h0);

    // R9 wake on pin 40 (bank 1 bit 8), interrupt mask closed
    wr(word_addr(OFS_WMSK, 1), 32'h100);
    wr(word_addr(OFS_REN, 1), 32'h100);
    pin_in[40] = 1'b1;
    step(3);
    chk("R9 wake_req", 64'(wake_req), 1);
    chk("R9 irq stays masked", 64'(irq), 0);
    rd(word_addr(OFS_WSTS, 1), r); chk("R9 wake status", 64'(r), 64'h100);
    wr(word_addr(OFS_WSTS, 1), 32'h100);
    chk("R9 wake cleared", 64'(wake_req), 0);
    rd(word_addr(OFS_STS, 1), r); chk("R9 status also set", 64'(r), 64'h100);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule